// File: doc/BRIEF.md
# Tape Controller Command and Start Front End

This block sits between a host's programmed-I/O strobes and a multi-drive tape subsystem. The host writes three registers from a shared data bus: a command/unit word, a memory address and a word count. It then fires a single-cycle start or clear pulse. On a start, the block inspects the selected drive and takes one of three paths. A drive that is not ready causes the command to finish at once with an illegal-operation error. A rewind or unload runs on the drive alone and leaves the controller idle. Any other command is a data operation: it marks the controller busy and is passed to a separate transfer engine.

The handoff to the transfer engine uses a one-cycle request pulse that carries the captured command code and drive number. The engine answers with a completion pulse and an error vector, which the block merges into its accumulated error status. The block also keeps a small state record for each drive: ready, rewinding and beginning-of-tape. A per-drive timer models the rewind travel. An online input marks each drive as present. Busy, done and the interrupt request follow the host's view of the controller. The interrupt is qualified by a mask input at the moment a command finishes.

Top module: `tape_cmd_front`

## Requirements
- R1: Each load strobe captures the bus on the next edge: the command/unit word and the memory address are taken as-is, and the word count takes bus bits 14:0 with bit 14 copied into bit 15.
- R2: A start pulse while busy is high has no effect on busy, the request pulse or any drive, even when it comes with a new command load.
- R3: A start to a drive that is not ready sets error bit 0 (illegal operation), leaves busy low, sets done, and sets the interrupt to the inverse of the mask input sampled in that cycle.
- R4: A start with command code 1 (rewind) or 17 (unload) in bits 7:3 to a ready drive clears that drive's ready and BOT flags and sets its rewinding flag. Busy, done, interrupt and error status stay unchanged. After REW_CYCLES cycles the rewinding flag drops and ready and BOT are set.
- R5: A start of any other command to a ready drive clears the error status, sets busy, and clears done and the interrupt. On the next cycle it raises op_req for exactly one cycle.
- R6: A data operation clears the selected drive's ready and BOT flags, except for code 2 (controller mode) and code 18 (drive mode), which leave the drive's flags untouched.
- R7: op_done while busy clears busy, sets done, sets the interrupt to the inverse of the mask, ORs op_err into the error status and sets the active drive ready. op_done while idle changes nothing.
- R8: A clear pulse zeroes busy, done, interrupt, error status and the command/unit word. It sets ready on the drive of an active data operation. A drive that is rewinding continues its rewind unaffected.
- R9: When start and clear arrive in the same cycle, only the clear acts.
- R10: The drive number (bits 2:0) and command code (bits 7:3) used by a start come from the bus when the command load occurs in the same cycle, and otherwise from the held command word. op_cmd and op_unit report the captured pair.
- R11: A drive whose online input is low reports not ready, and a start to it is rejected as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 16 | Host data bus for register loads |
| ld_cmd | input | 1 | Load command/unit word |
| ld_addr | input | 1 | Load memory address |
| ld_count | input | 1 | Load word count |
| start_p | input | 1 | Start pulse |
| clear_p | input | 1 | Clear pulse |
| irq_mask | input | 1 | Interrupt mask for this controller |
| drv_online | input | 8 | Drive present per unit |
| op_done | input | 1 | Transfer engine completion pulse |
| op_err | input | 8 | Error flags reported with op_done |
| cmd_word | output | 16 | Held command/unit word |
| mem_addr | output | 16 | Held memory address |
| word_count | output | 16 | Held word count |
| busy | output | 1 | Controller busy |
| done | output | 1 | Controller done |
| irq | output | 1 | Interrupt request |
| err_status | output | 8 | Accumulated error flags, bit 0 illegal operation |
| op_req | output | 1 | One-cycle request to the transfer engine |
| op_cmd | output | 5 | Command code of the request |
| op_unit | output | 3 | Drive number of the request |
| drv_ready | output | 8 | Per-drive ready |
| drv_rewinding | output | 8 | Per-drive rewinding |
| drv_bot | output | 8 | Per-drive beginning of tape |

## Verification
A wrong busy or done bit shows on the next cycle. It also shows later in which starts get accepted: a stuck busy silently eats every later start, and this appears as a missing op_req one cycle after the start pulse. Drive state mistakes are slower to surface. A wrongly kept ready bit only shows when a later start to that drive should have been rejected. A wrong rewind count only shows REW_CYCLES cycles after the rewind began. The bench therefore compares every output against its model on every clock, so such divergences are caught at their first visible cycle.

// File: rtl/tape_ctl_pkg.sv
package tape_ctl_pkg;

    localparam int CMD_LSB     = 3;
    localparam int CMD_W       = 5;
    localparam int ERR_W       = 8;
    localparam int ERR_ILLEGAL = 0;

    typedef enum logic [CMD_W-1:0] {
        OP_READ    = 5'd0,
        OP_REWIND  = 5'd1,
        OP_CTLMODE = 5'd2,
        OP_SPFWD   = 5'd3,
        OP_SPREV   = 5'd4,
        OP_WRITE   = 5'd5,
        OP_WMARK   = 5'd6,
        OP_ERASE   = 5'd7,
        OP_READNS  = 5'd16,
        OP_UNLOAD  = 5'd17,
        OP_DRVMODE = 5'd18
    } tape_op_e;

    // Commands that run on the drive alone
    function automatic logic drive_local(input logic [CMD_W-1:0] code);
        return (code == OP_REWIND) || (code == OP_UNLOAD);
    endfunction

    // Mode settings do not move tape, so the drive stays ready
    function automatic logic keeps_drive(input logic [CMD_W-1:0] code);
        return (code == OP_CTLMODE) || (code == OP_DRVMODE);
    endfunction

endpackage

// File: rtl/tape_cmd_regs.sv
module tape_cmd_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              ld_cmd,
    input  logic              ld_addr,
    input  logic              ld_count,
    input  logic              clr_cmd,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] cmd_eff
);
    localparam int TOP = DATA_W - 2;

    assign cmd_eff = ld_cmd ? bus_data : cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            count_q <= '0;
        end else begin
            if (clr_cmd)     cmd_q <= '0;
            else if (ld_cmd) cmd_q <= bus_data;
            if (ld_addr)     addr_q <= bus_data;
            if (ld_count)    count_q <= {bus_data[TOP], bus_data[TOP:0]};
        end
    end

    assert_count_sext_R1: assert property (@(posedge clk) disable iff (rst)
        ld_count |=> (count_q[DATA_W-1] == count_q[TOP]));

endmodule

// File: rtl/tape_drive.sv
module tape_drive #(
    parameter int REW_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic online,
    input  logic go_rew,
    input  logic go_data,
    input  logic set_ready,
    output logic ready,
    output logic rewinding,
    output logic bot
);
    localparam int CNT_W = $clog2(REW_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REW_CYCLES - 1);

    logic             rdy_q;
    logic             rew_q;
    logic             bot_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= 1'b1;
            rew_q <= 1'b0;
            bot_q <= 1'b1;
            cnt_q <= '0;
        end else if (go_rew) begin
            rdy_q <= 1'b0;
            bot_q <= 1'b0;
            rew_q <= 1'b1;
            cnt_q <= CNT_LAST;
        end else if (go_data) begin
            rdy_q <= 1'b0;
            bot_q <= 1'b0;
        end else if (rew_q) begin
            if (cnt_q == '0) begin
                rew_q <= 1'b0;
                rdy_q <= 1'b1;
                bot_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (set_ready) begin
            rdy_q <= 1'b1;
        end
    end

    assign ready     = rdy_q & online;
    assign rewinding = rew_q;
    assign bot       = bot_q;

    assert_rew_notready_R4: assert property (@(posedge clk) disable iff (rst)
        rew_q |-> !rdy_q);

    assert_rew_start_R4: assert property (@(posedge clk) disable iff (rst)
        go_rew |=> (rew_q && !bot_q));

endmodule

// File: rtl/tape_seq.sv
module tape_seq
    import tape_ctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int N_DRV  = 8,
    parameter int UNIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_p,
    input  logic              clear_p,
    input  logic              irq_mask,
    input  logic [DATA_W-1:0] cmd_eff,
    input  logic [N_DRV-1:0]  drv_ready,
    input  logic [N_DRV-1:0]  drv_rewinding,
    input  logic              op_done,
    input  logic [ERR_W-1:0]  op_err,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic [ERR_W-1:0]  err_status,
    output logic              op_req,
    output logic [CMD_W-1:0]  op_cmd,
    output logic [UNIT_W-1:0] op_unit,
    output logic [N_DRV-1:0]  go_rew,
    output logic [N_DRV-1:0]  go_data,
    output logic [N_DRV-1:0]  set_ready
);
    logic              busy_q, done_q, irq_q, req_q;
    logic [ERR_W-1:0]  err_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [UNIT_W-1:0] unit_q;

    logic [UNIT_W-1:0] sel_unit;
    logic [CMD_W-1:0]  sel_code;
    logic              start_ok, sel_rdy, rew_start, data_start, reject, finish;

    always_comb begin
        sel_unit   = cmd_eff[UNIT_W-1:0];
        sel_code   = cmd_eff[CMD_LSB +: CMD_W];
        start_ok   = start_p && !clear_p && !busy_q;
        sel_rdy    = drv_ready[sel_unit];
        reject     = start_ok && !sel_rdy;
        rew_start  = start_ok && sel_rdy && drive_local(sel_code);
        data_start = start_ok && sel_rdy && !drive_local(sel_code);
        finish     = op_done && busy_q && !clear_p;
        for (int d = 0; d < N_DRV; d++) begin
            go_rew[d]    = rew_start && (sel_unit == UNIT_W'(d));
            go_data[d]   = data_start && !keeps_drive(sel_code) && (sel_unit == UNIT_W'(d));
            set_ready[d] = busy_q && (unit_q == UNIT_W'(d)) && !drv_rewinding[d]
                           && (clear_p || op_done);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            req_q  <= 1'b0;
            err_q  <= '0;
            cmd_q  <= '0;
            unit_q <= '0;
        end else begin
            req_q <= data_start;
            if (clear_p) begin
                busy_q <= 1'b0;
                done_q <= 1'b0;
                irq_q  <= 1'b0;
                err_q  <= '0;
            end else if (reject) begin
                err_q[ERR_ILLEGAL] <= 1'b1;
                done_q <= 1'b1;
                irq_q  <= !irq_mask;
            end else if (data_start) begin
                err_q  <= '0;
                busy_q <= 1'b1;
                done_q <= 1'b0;
                irq_q  <= 1'b0;
                cmd_q  <= sel_code;
                unit_q <= sel_unit;
            end else if (finish) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                irq_q  <= !irq_mask;
                err_q  <= err_q | op_err;
            end
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign irq        = irq_q;
    assign err_status = err_q;
    assign op_req     = req_q;
    assign op_cmd     = cmd_q;
    assign op_unit    = unit_q;

    assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start_p && !clear_p && !op_done) |=> (busy_q && !req_q));

    assert_reject_R3: assert property (@(posedge clk) disable iff (rst)
        (start_p && !clear_p && !busy_q && !drv_ready[cmd_eff[UNIT_W-1:0]])
        |=> (done_q && err_q[ERR_ILLEGAL] && !busy_q));

    assert_local_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (|go_rew) |=> !busy_q);

    assert_req_busy_R5: assert property (@(posedge clk) disable iff (rst)
        req_q |-> busy_q);

    assert_irq_done_R7: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> done_q);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clear_p |=> (!busy_q && !done_q && !irq_q && err_q == '0));

endmodule

// File: rtl/tape_cmd_front.sv
module tape_cmd_front
    import tape_ctl_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int N_DRV      = 8,
    parameter int REW_CYCLES = 20
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DATA_W-1:0]          bus_data,
    input  logic                       ld_cmd,
    input  logic                       ld_addr,
    input  logic                       ld_count,
    input  logic                       start_p,
    input  logic                       clear_p,
    input  logic                       irq_mask,
    input  logic [N_DRV-1:0]           drv_online,
    input  logic                       op_done,
    input  logic [ERR_W-1:0]           op_err,
    output logic [DATA_W-1:0]          cmd_word,
    output logic [DATA_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          word_count,
    output logic                       busy,
    output logic                       done,
    output logic                       irq,
    output logic [ERR_W-1:0]           err_status,
    output logic                       op_req,
    output logic [CMD_W-1:0]           op_cmd,
    output logic [$clog2(N_DRV)-1:0]   op_unit,
    output logic [N_DRV-1:0]           drv_ready,
    output logic [N_DRV-1:0]           drv_rewinding,
    output logic [N_DRV-1:0]           drv_bot
);
    localparam int UNIT_W = $clog2(N_DRV);

    logic [DATA_W-1:0] cmd_eff;
    logic [N_DRV-1:0]  go_rew, go_data, set_ready;

    tape_cmd_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_data (bus_data),
        .ld_cmd   (ld_cmd),
        .ld_addr  (ld_addr),
        .ld_count (ld_count),
        .clr_cmd  (clear_p),
        .cmd_q    (cmd_word),
        .addr_q   (mem_addr),
        .count_q  (word_count),
        .cmd_eff  (cmd_eff)
    );

    tape_seq #(.DATA_W(DATA_W), .N_DRV(N_DRV), .UNIT_W(UNIT_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_p       (start_p),
        .clear_p       (clear_p),
        .irq_mask      (irq_mask),
        .cmd_eff       (cmd_eff),
        .drv_ready     (drv_ready),
        .drv_rewinding (drv_rewinding),
        .op_done       (op_done),
        .op_err        (op_err),
        .busy          (busy),
        .done          (done),
        .irq           (irq),
        .err_status    (err_status),
        .op_req        (op_req),
        .op_cmd        (op_cmd),
        .op_unit       (op_unit),
        .go_rew        (go_rew),
        .go_data       (go_data),
        .set_ready     (set_ready)
    );

    for (genvar d = 0; d < N_DRV; d++) begin : g_drv
        tape_drive #(.REW_CYCLES(REW_CYCLES)) u_drv (
            .clk       (clk),
            .rst       (rst),
            .online    (drv_online[d]),
            .go_rew    (go_rew[d]),
            .go_data   (go_data[d]),
            .set_ready (set_ready[d]),
            .ready     (drv_ready[d]),
            .rewinding (drv_rewinding[d]),
            .bot       (drv_bot[d])
        );
    end

    assert_offline_R11: assert property (@(posedge clk) disable iff (rst)
        ((drv_ready & ~drv_online) == '0));

endmodule

// File: tb/tb_tape_cmd_front.sv
module tb_tape_cmd_front;
    localparam int CLK_PERIOD = 10;
    localparam int REW = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_data = '0;
    logic        ld_cmd = 0, ld_addr = 0, ld_count = 0;
    logic        start_p = 0, clear_p = 0, irq_mask = 0, op_done = 0;
    logic [7:0]  drv_online = 8'hFF;
    logic [7:0]  op_err = '0;

    logic [15:0] cmd_word, mem_addr, word_count;
    logic        busy, done, irq, op_req;
    logic [7:0]  err_status, drv_ready, drv_rewinding, drv_bot;
    logic [4:0]  op_cmd;
    logic [2:0]  op_unit;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // reference state
    logic [15:0] m_cmd, m_addr, m_cnt_w;
    logic        m_busy, m_done, m_irq, m_req;
    logic [7:0]  m_err, m_rdy, m_rew, m_bot;
    logic [4:0]  m_opc;
    logic [2:0]  m_opu;
    int          m_rc[8];

    tape_cmd_front #(.DATA_W(16), .N_DRV(8), .REW_CYCLES(REW)) dut (
        .clk(clk), .rst(rst), .bus_data(bus_data), .ld_cmd(ld_cmd), .ld_addr(ld_addr),
        .ld_count(ld_count), .start_p(start_p), .clear_p(clear_p), .irq_mask(irq_mask),
        .drv_online(drv_online), .op_done(op_done), .op_err(op_err),
        .cmd_word(cmd_word), .mem_addr(mem_addr), .word_count(word_count),
        .busy(busy), .done(done), .irq(irq), .err_status(err_status), .op_req(op_req),
        .op_cmd(op_cmd), .op_unit(op_unit), .drv_ready(drv_ready),
        .drv_rewinding(drv_rewinding), .drv_bot(drv_bot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [15:0] eff;
        logic [2:0]  u;
        logic [4:0]  c;
        logic        o_busy;
        logic [2:0]  o_u;
        logic [7:0]  o_rew, view;
        if (rst) begin
            m_cmd = 0; m_addr = 0; m_cnt_w = 0;
            m_busy = 0; m_done = 0; m_irq = 0; m_req = 0; m_err = 0;
            m_rdy = 8'hFF; m_rew = 0; m_bot = 8'hFF; m_opc = 0; m_opu = 0;
            for (int d = 0; d < 8; d++) m_rc[d] = 0;
            return;
        end
        eff = ld_cmd ? bus_data : m_cmd;
        u = eff[2:0];
        c = eff[7:3];
        o_busy = m_busy; o_u = m_opu; o_rew = m_rew; view = m_rdy & drv_online;
        // rewind travel
        for (int d = 0; d < 8; d++) begin
            if (o_rew[d]) begin
                if (m_rc[d] == 0) begin m_rew[d] = 0; m_rdy[d] = 1; m_bot[d] = 1; end
                else m_rc[d]--;
            end
        end
        if (clear_p) m_cmd = 0; else if (ld_cmd) m_cmd = bus_data;
        if (ld_addr) m_addr = bus_data;
        if (ld_count) m_cnt_w = {bus_data[14], bus_data[14:0]};
        m_req = 0;
        if (clear_p) begin
            m_busy = 0; m_done = 0; m_irq = 0; m_err = 0;
            if (o_busy && !o_rew[o_u]) m_rdy[o_u] = 1;
        end else if (start_p && !o_busy) begin
            if (!view[u]) begin
                m_err[0] = 1; m_done = 1; m_irq = !irq_mask;
            end else if (c == 5'd1 || c == 5'd17) begin
                m_rew[u] = 1; m_rc[u] = REW - 1; m_rdy[u] = 0; m_bot[u] = 0;
            end else begin
                m_err = 0; m_busy = 1; m_done = 0; m_irq = 0; m_req = 1;
                m_opc = c; m_opu = u;
                if (c != 5'd2 && c != 5'd18) begin m_rdy[u] = 0; m_bot[u] = 0; end
            end
        end else if (op_done && o_busy) begin
            m_busy = 0; m_done = 1; m_irq = !irq_mask; m_err = m_err | op_err;
            m_rdy[o_u] = 1;
        end
    endtask

    task automatic compare_all();
        check("R1", "cmd_word", 32'(cmd_word), 32'(m_cmd));
        check("R1", "mem_addr", 32'(mem_addr), 32'(m_addr));
        check("R1", "word_count", 32'(word_count), 32'(m_cnt_w));
        check("R5", "busy", 32'(busy), 32'(m_busy));
        check("R7", "done", 32'(done), 32'(m_done));
        check("R3", "irq", 32'(irq), 32'(m_irq));
        check("R8", "err_status", 32'(err_status), 32'(m_err));
        check("R5", "op_req", 32'(op_req), 32'(m_req));
        check("R10", "op_cmd", 32'(op_cmd), 32'(m_opc));
        check("R10", "op_unit", 32'(op_unit), 32'(m_opu));
        check("R6", "drv_ready", 32'(drv_ready), 32'(m_rdy & drv_online));
        check("R4", "drv_rewinding", 32'(drv_rewinding), 32'(m_rew));
        check("R4", "drv_bot", 32'(drv_bot), 32'(m_bot));
    endtask

    // one clock: inputs already set; model follows the edge; compare at falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        ld_cmd = 0; ld_addr = 0; ld_count = 0; start_p = 0; clear_p = 0; op_done = 0;
        op_err = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        idle(2);
        rst = 0;
        // reset state
        check("R1", "reset cmd_word", 32'(cmd_word), 0);
        check("R5", "reset busy", 32'(busy), 0);
        check("R6", "reset ready", 32'(drv_ready), 32'hFF);
        // R1 loads
        bus_data = 16'h1234; ld_addr = 1; tick();
        bus_data = 16'h4005; ld_count = 1; tick();
        check("R1", "count sext", 32'(word_count), 32'hC005);
        bus_data = 16'h3FFF; ld_count = 1; tick();
        check("R1", "count positive", 32'(word_count), 32'h3FFF);
        // R5 data op read unit 0
        bus_data = 16'h0000; ld_cmd = 1; tick();
        start_p = 1; tick();
        check("R5", "busy after start", 32'(busy), 1);
        tick();
        check("R5", "op_req one cycle", 32'(op_req), 0);
        check("R6", "unit0 not ready", 32'(drv_ready[0]), 0);
        idle(2);
        irq_mask = 0; op_err = 8'h04; op_done = 1; tick();
        check("R7", "irq on completion", 32'(irq), 1);
        check("R7", "err merged", 32'(err_status), 32'h04);
        // write unit 1, mask set
        bus_data = 16'h0029; ld_cmd = 1; start_p = 1; tick();
        check("R8", "err cleared by data start", 32'(err_status), 0);
        tick();
        // R2 start while busy with new rewind command to unit 2
        bus_data = 16'h000A; ld_cmd = 1; start_p = 1; tick();
        check("R2", "ignored start no rewind", 32'(drv_rewinding[2]), 0);
        check("R2", "ignored start busy", 32'(busy), 1);
        tick();
        check("R2", "ignored start no req", 32'(op_req), 0);
        irq_mask = 1; op_done = 1; tick();
        check("R7", "masked irq", 32'(irq), 0);
        irq_mask = 0;
        // R7 op_done while idle
        op_err = 8'hF0; op_done = 1; tick();
        check("R7", "idle done ignored", 32'(err_status), 0);
        // R4 rewind unit 3, unload unit 4
        bus_data = 16'h000B; ld_cmd = 1; start_p = 1; tick();
        check("R4", "rewind keeps idle", 32'(busy), 0);
        bus_data = 16'h008C; ld_cmd = 1; start_p = 1; tick();
        check("R4", "unload rewinding", 32'(drv_rewinding[4]), 1);
        // R3 start to rewinding unit 3
        bus_data = 16'h0003; ld_cmd = 1; start_p = 1; tick();
        check("R3", "illegal flag", 32'(err_status[0]), 1);
        idle(REW);
        check("R4", "rewind finished ready", 32'(drv_ready[3]), 1);
        check("R4", "rewind finished bot", 32'(drv_bot[3]), 1);
        // R11 offline unit 6
        drv_online[6] = 0; tick();
        check("R11", "offline not ready", 32'(drv_ready[6]), 0);
        bus_data = 16'h0006; ld_cmd = 1; start_p = 1; tick();
        check("R11", "offline reject", 32'(err_status[0] & done & !busy), 1);
        drv_online[6] = 1;
        // R6 controller mode unit 5 keeps ready
        bus_data = 16'h0015; ld_cmd = 1; start_p = 1; tick();
        check("R6", "mode keeps ready", 32'(drv_ready[5]), 1);
        op_done = 1; tick();
        // drive mode unit 5
        bus_data = 16'h0095; ld_cmd = 1; start_p = 1; tick();
        check("R6", "drive mode keeps bot", 32'(drv_bot[5]), 1);
        op_done = 1; tick();
        // R8 clear during data op with rewind running; R10 same-cycle load
        bus_data = 16'h000A; ld_cmd = 1; start_p = 1; tick();
        bus_data = 16'h0087; ld_cmd = 1; start_p = 1; tick();
        check("R10", "busy from loaded cmd", 32'(busy), 1);
        tick();
        check("R10", "op_unit", 32'(op_unit), 7);
        check("R10", "op_cmd", 32'(op_cmd), 16);
        clear_p = 1; tick();
        check("R8", "abort sets ready", 32'(drv_ready[7]), 1);
        check("R8", "rewind continues", 32'(drv_rewinding[2]), 1);
        check("R8", "cmd cleared", 32'(cmd_word), 0);
        // R9 clear and start together
        bus_data = 16'h0001; ld_cmd = 1; start_p = 1; clear_p = 1; tick();
        check("R9", "clear wins busy", 32'(busy), 0);
        tick();
        check("R9", "clear wins req", 32'(op_req), 0);
        check("R9", "clear wins ready", 32'(drv_ready[1]), 1);
        idle(REW + 2);
        finish_run();
    end
endmodule